// File: doc/BRIEF.md
# Configurable UART Serial Framing Core

This block is the serial engine of a UART. The transmitter accepts one byte at a time over a valid/ready handshake. It sends the byte as a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. The receiver watches the serial input and rebuilds each character. It presents the character with parity, framing and overrun flags, and holds it until the consumer takes it.

A 4-bit format word chooses 7 or 8 data bits, none, odd or even parity, and 1 or 2 stop bits. The transmitter captures the format when it accepts a byte. The receiver captures it when it detects a start bit. Both sides share one 12-bit divisor. Each bit lasts 16 × (divisor + 1) clock cycles, and the receiver counts in sixteenths of a bit.

Break forces the serial output low. Loopback feeds the receiver from the transmitter's own output in place of the external pin. Separate enables return either side to idle.

Top module: `serial_frame_core`

## Requirements
- R1: Every transmitted bit lasts exactly 16 × (`baud_div` + 1) clock cycles. `tx_busy` stays high for the frame length in bits times that figure.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. The format bits are: `fmt[0]` parity on, `fmt[1]` even parity (odd when clear), `fmt[2]` two stop bits, `fmt[3]` eight data bits (seven when clear). After a frame, `txd` idles high.
- R3: With even parity the data plus parity bit hold an even count of ones. With odd parity they hold an odd count.
- R4: When `tx_valid` is high and `tx_ready` is high, the byte is accepted. `tx_busy` rises on the next cycle and `tx_ready` is low while `tx_busy` is high. `tx_ready` equals `tx_en` and not busy.
- R5: While `brk` is high, `txd` is low on every cycle.
- R6: While `loopback` is high, the receiver decodes `txd` and ignores `rxd`.
- R7: A received character appears on `rx_data` with `rx_valid` high. It holds unchanged until `rx_take`. In 7-bit mode `rx_data[7]` is 0.
- R8: `rx_perr` is set when the received parity bit does not match the selected parity. It is 0 when parity is off.
- R9: `rx_ferr` is set when the first stop bit is sampled low. A low second stop bit is not flagged.
- R10: If a character completes while `rx_valid` is high and `rx_take` is low, the new character replaces the old one with `rx_ovr` set. A take in the same cycle as the completion gives `rx_ovr` = 0.
- R11: Each bit is sampled 8 sixteenths after its start. A start bit that is high again at that point produces no character.
- R12: Clearing `tx_en` ends a frame in progress: `tx_busy` drops and `txd` goes high. While `rx_en` is low, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 12 | Bit-rate divisor; bit time is 16 × (baud_div + 1) cycles |
| fmt | input | 4 | Format: parity on, even, two stop, eight bits (bits 0..3) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| brk | input | 1 | Force serial output low |
| loopback | input | 1 | Receiver takes its input from txd |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_busy | output | 1 | A frame is being shifted out |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character held and unread |
| rx_perr | output | 1 | Parity error on held character |
| rx_ferr | output | 1 | Framing error on held character |
| rx_ovr | output | 1 | Held character overwrote an unread one |
| rx_take | input | 1 | Consumer takes the held character |

## Verification
Two things can fall in the same cycle: the receiver finishing a character (at mid-stop), and the consumer taking the previous, still-unread one. The bench counts the synchronizer and oversampling delays to find the exact completion cycle. It raises `rx_take` for that single cycle while a second character arrives behind an unread first one. The new character must then be held with `rx_ovr` clear. A separate run without the take must show `rx_ovr` set and the second byte held.

// File: rtl/serial_frame_core.sv
module serial_frame_core #(
  parameter int DIV_W = 12,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [3:0]       fmt,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             brk,
  input  logic             loopback,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr,
  input  logic             rx_take
);
  localparam int OVS = 1 << SUB_W;
  localparam int MID = OVS / 2 - 1;
  localparam int FW  = 12;
  localparam int CW  = 4;

  wire par_on   = fmt[0];
  wire par_even = fmt[1];
  wire two_stop = fmt[2];
  wire eight    = fmt[3];

  // transmitter
  logic             tx_act;
  logic [FW-1:0]    tx_sh;
  logic [CW-1:0]    tx_left;
  logic [DIV_W-1:0] tx_pre;
  logic [SUB_W-1:0] tx_sub;
  logic [FW-1:0]    frame;
  logic [CW-1:0]    frame_len;
  logic             pbit;

  assign pbit = (eight ? ^tx_data : ^tx_data[6:0]) ^ ~par_even;

  always_comb begin
    frame      = '1;
    frame[0]   = 1'b0;
    frame[7:1] = tx_data[6:0];
    frame[8]   = eight ? tx_data[7] : (par_on ? pbit : 1'b1);
    frame[9]   = (eight && par_on) ? pbit : 1'b1;
    frame_len  = CW'(9) + CW'(eight) + CW'(par_on) + CW'(two_stop);
  end

  wire tx_tick = (tx_pre == baud_div);

  assign tx_ready = tx_en & ~tx_act;
  assign tx_busy  = tx_act;
  assign txd      = ~brk & (~tx_act | tx_sh[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act  <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_pre  <= '0;
      tx_sub  <= '0;
    end else if (!tx_en) begin
      tx_act <= 1'b0;
      tx_pre <= '0;
      tx_sub <= '0;
    end else if (tx_valid && !tx_act) begin
      tx_act  <= 1'b1;
      tx_sh   <= frame;
      tx_left <= frame_len;
      tx_pre  <= '0;
      tx_sub  <= '0;
    end else if (tx_act) begin
      if (tx_tick) begin
        tx_pre <= '0;
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == SUB_W'(OVS - 1)) begin
          tx_sh   <= {1'b1, tx_sh[FW-1:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == CW'(1)) tx_act <= 1'b0;
        end
      end else begin
        tx_pre <= tx_pre + 1'b1;
      end
    end
  end

  // receiver
  logic             s1, rx_line;
  logic             rx_act;
  logic [DIV_W-1:0] rx_pre;
  logic [SUB_W-1:0] rx_sub;
  logic [CW-1:0]    rx_idx;
  logic [7:0]       rx_sh;
  logic             rx_pacc, rx_perr_q;
  logic [3:0]       rx_fmt;

  wire rx_src = loopback ? txd : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      rx_line <= 1'b1;
    end else begin
      s1      <= rx_src;
      rx_line <= s1;
    end
  end

  wire          rx_tick  = (rx_pre == baud_div);
  wire          rx_mid   = rx_act && rx_tick && (rx_sub == SUB_W'(MID));
  wire [CW-1:0] rx_nd    = rx_fmt[3] ? CW'(8) : CW'(7);
  wire [CW-1:0] stop_idx = CW'(1) + rx_nd + CW'(rx_fmt[0]);
  wire          rx_done  = rx_mid && (rx_idx == stop_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act    <= 1'b0;
      rx_pre    <= '0;
      rx_sub    <= '0;
      rx_idx    <= '0;
      rx_sh     <= '0;
      rx_pacc   <= 1'b0;
      rx_perr_q <= 1'b0;
      rx_fmt    <= '0;
    end else if (!rx_en) begin
      rx_act <= 1'b0;
    end else if (!rx_act) begin
      if (!rx_line) begin
        rx_act    <= 1'b1;
        rx_pre    <= '0;
        rx_sub    <= '0;
        rx_idx    <= '0;
        rx_sh     <= '0;
        rx_pacc   <= 1'b0;
        rx_perr_q <= 1'b0;
        rx_fmt    <= fmt;
      end
    end else begin
      if (rx_tick) begin
        rx_pre <= '0;
        rx_sub <= rx_sub + 1'b1;
      end else begin
        rx_pre <= rx_pre + 1'b1;
      end
      if (rx_mid) begin
        if (rx_idx == '0) begin
          if (rx_line) rx_act <= 1'b0;
          else         rx_idx <= rx_idx + 1'b1;
        end else if (rx_idx <= rx_nd) begin
          rx_sh[3'(rx_idx - 1'b1)] <= rx_line;
          rx_pacc <= rx_pacc ^ rx_line;
          rx_idx  <= rx_idx + 1'b1;
        end else if (rx_idx == stop_idx) begin
          rx_act <= 1'b0;
        end else begin
          rx_perr_q <= rx_pacc ^ rx_line ^ ~rx_fmt[1];
          rx_idx    <= rx_idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
    end else if (rx_done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_sh;
      rx_perr  <= rx_fmt[0] & rx_perr_q;
      rx_ferr  <= ~rx_line;
      rx_ovr   <= rx_valid & ~rx_take;
    end else if (rx_take) begin
      rx_valid <= 1'b0;
    end
  end

  // R12
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_busy);

  // R5
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> tx_busy && !tx_ready);

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_valid && !rx_take |=> rx_valid && rx_ovr);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_take && !rx_done |=> rx_valid && $stable(rx_data));

  // R11
  glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mid && rx_idx == '0 && rx_line && rx_en |=> !rx_act);

endmodule

// File: tb/serial_frame_core_test.sv
module serial_frame_core_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [11:0] baud_div = 12'd1;
  logic [3:0]  fmt = 4'b1000;
  logic        tx_en = 1'b1, rx_en = 1'b1, brk = 1'b0, loopback = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_busy, txd;
  logic        rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_perr, rx_ferr, rx_ovr;
  logic        rx_take = 1'b0;

  int total = 0;
  int bad = 0;

  serial_frame_core uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .fmt(fmt),
    .tx_en(tx_en), .rx_en(rx_en), .brk(brk), .loopback(loopback),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_ovr(rx_ovr), .rx_take(rx_take)
  );

  function automatic int bit_t();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] d, input logic [3:0] f,
                       output logic [11:0] fr, output int n, output int pidx);
    int nd;
    logic p;
    nd = f[3] ? 8 : 7;
    fr = '1;
    fr[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      fr[1 + i] = d[i];
      p ^= d[i];
    end
    pidx = 1 + nd;
    if (f[0]) fr[1 + nd] = f[1] ? p : ~p;
    n = 1 + nd + int'(f[0]) + 1 + int'(f[2]);
  endtask

  task automatic take();
    @(negedge clk) rx_take = 1'b1;
    @(negedge clk) rx_take = 1'b0;
  endtask

  // drive one frame on rxd; call just after a negedge
  task automatic rx_send(input logic [7:0] d, input logic [3:0] f,
                         input bit bad_par, input bit bad_s1, input bit bad_s2);
    logic [11:0] fr;
    int n, pidx, sidx;
    build(d, f, fr, n, pidx);
    sidx = pidx + int'(f[0]);
    if (bad_par) fr[pidx] = ~fr[pidx];
    if (bad_s1) fr[sidx] = 1'b0;
    if (bad_s2) fr[sidx + 1] = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxd = fr[i];
      repeat (bit_t()) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic settle();
    repeat (14 * bit_t()) @(negedge clk);
    take();
  endtask

  // send a byte and check its waveform
  task automatic tx_frame(input logic [7:0] d, input logic [3:0] f, input string req);
    logic [11:0] fr, got;
    int n, pidx, k, t;
    build(d, f, fr, n, pidx);
    t = bit_t();
    got = '1;
    @(negedge clk);
    fmt = f; tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R4", "busy after accept", int'(tx_busy), 1);
    check("R4", "ready while busy", int'(tx_ready), 0);
    k = 0;
    while (tx_busy && k < 20 * t) begin
      if (k % t == t / 2) got[k / t] = txd;
      k++;
      @(negedge clk);
    end
    check("R1", "busy length", k, n * t);
    check(req, "frame bits", int'(got & 12'((1 << n) - 1)), int'(fr & 12'((1 << n) - 1)));
    check("R2", "idle high", int'(txd), 1);
  endtask

  task automatic t_reset();
    check("R4", "reset busy", int'(tx_busy), 0);
    check("R2", "reset txd", int'(txd), 1);
    check("R7", "reset rx_valid", int'(rx_valid), 0);
    check("R4", "reset ready", int'(tx_ready), 1);
  endtask

  task automatic t_tx_formats();
    tx_frame(8'hA5, 4'b1000, "R2");
    tx_frame(8'h53, 4'b0111, "R3");
    tx_frame(8'h81, 4'b1001, "R3");
    tx_frame(8'h3C, 4'b1011, "R3");
    tx_frame(8'h7E, 4'b1100, "R2");
    baud_div = 12'd5;
    tx_frame(8'h41, 4'b0001, "R1");
    baud_div = 12'd1;
  endtask

  task automatic t_break();
    int highs = 0;
    brk = 1'b1;
    repeat (3 * bit_t()) begin
      @(negedge clk);
      if (txd) highs++;
    end
    check("R5", "txd high during break", highs, 0);
    check("R5", "busy during break", int'(tx_busy), 0);
    brk = 1'b0;
    @(negedge clk);
    check("R5", "txd after break", int'(txd), 1);
  endtask

  task automatic t_loopback();
    @(negedge clk);
    loopback = 1'b1; rxd = 1'b0;
    tx_frame(8'hC3, 4'b1000, "R6");
    repeat (4) @(negedge clk);
    check("R6", "loop valid", int'(rx_valid), 1);
    check("R6", "loop data", int'(rx_data), 8'hC3);
    check("R6", "loop ferr", int'(rx_ferr), 0);
    take();
    loopback = 1'b0; rxd = 1'b1;
    repeat (2 * bit_t()) @(negedge clk);
    check("R6", "no char from rxd", int'(rx_valid), 0);
  endtask

  task automatic t_rx_basic();
    @(negedge clk);
    fmt = 4'b1000;
    rx_send(8'h96, 4'b1000, 0, 0, 0);
    check("R7", "valid", int'(rx_valid), 1);
    check("R7", "data 8N1", int'(rx_data), 8'h96);
    check("R8", "perr off", int'(rx_perr), 0);
    repeat (3 * bit_t()) @(negedge clk);
    check("R7", "still held", int'(rx_data), 8'h96);
    take();
    check("R7", "cleared by take", int'(rx_valid), 0);
    fmt = 4'b0000;
    rx_send(8'hFF, 4'b0000, 0, 0, 0);
    check("R7", "7-bit data", int'(rx_data), 8'h7F);
    take();
    baud_div = 12'd5;
    rx_send(8'h2B, 4'b1001, 0, 0, 0);
    check("R1", "rx at div 5", int'(rx_data), 8'h2B);
    check("R8", "odd ok", int'(rx_perr), 0);
    take();
    baud_div = 12'd1;
  endtask

  task automatic t_rx_parity();
    @(negedge clk);
    fmt = 4'b1011;
    rx_send(8'h71, 4'b1011, 1, 0, 0);
    check("R8", "bad even parity", int'(rx_perr), 1);
    check("R8", "data with perr", int'(rx_data), 8'h71);
    take();
    fmt = 4'b0111;
    rx_send(8'h35, 4'b0111, 0, 0, 0);
    check("R8", "good even 7-bit", int'(rx_perr), 0);
    settle();
  endtask

  task automatic t_rx_frame();
    @(negedge clk);
    fmt = 4'b1000;
    rx_send(8'h5A, 4'b1000, 0, 1, 0);
    check("R9", "ferr set", int'(rx_ferr), 1);
    settle();
    fmt = 4'b1100;
    @(negedge clk);
    rx_send(8'h5A, 4'b1100, 0, 0, 1);
    check("R9", "second stop ignored", int'(rx_ferr), 0);
    check("R9", "data", int'(rx_data), 8'h5A);
    settle();
    fmt = 4'b1000;
  endtask

  task automatic t_overrun();
    int d;
    @(negedge clk);
    rx_send(8'h11, 4'b1000, 0, 0, 0);
    rx_send(8'h22, 4'b1000, 0, 0, 0);
    check("R10", "ovr set", int'(rx_ovr), 1);
    check("R10", "newer data", int'(rx_data), 8'h22);
    take();
    // take lands in the completion cycle
    rx_send(8'h33, 4'b1000, 0, 0, 0);
    d = 3 + (8 + 16 * 9) * (int'(baud_div) + 1);
    fork
      rx_send(8'h44, 4'b1000, 0, 0, 0);
      begin
        repeat (d - 1) @(posedge clk);
        @(negedge clk) rx_take = 1'b1;
        @(negedge clk) rx_take = 1'b0;
      end
    join
    check("R10", "collision valid", int'(rx_valid), 1);
    check("R10", "collision data", int'(rx_data), 8'h44);
    check("R10", "collision no ovr", int'(rx_ovr), 0);
    take();
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_t()) @(negedge clk);
    check("R11", "glitch rejected", int'(rx_valid), 0);
    rx_send(8'hE7, 4'b1000, 0, 0, 0);
    check("R11", "after glitch", int'(rx_data), 8'hE7);
    take();
  endtask

  task automatic t_enables();
    @(negedge clk);
    rx_en = 1'b0;
    rx_send(8'h99, 4'b1000, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R12", "rx disabled", int'(rx_valid), 0);
    rx_en = 1'b1;
    tx_data = 8'h00; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (3 * bit_t()) @(negedge clk);
    check("R12", "busy mid-frame", int'(tx_busy), 1);
    tx_en = 1'b0;
    @(negedge clk);
    check("R12", "busy after disable", int'(tx_busy), 0);
    check("R12", "txd after disable", int'(txd), 1);
    check("R4", "ready when disabled", int'(tx_ready), 0);
    tx_en = 1'b1;
    @(negedge clk);
    check("R4", "ready re-enabled", int'(tx_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_formats();
    t_break();
    t_loopback();
    t_rx_basic();
    t_rx_parity();
    t_rx_frame();
    t_overrun();
    t_glitch();
    t_enables();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule